// File: doc/BRIEF.md
# Interleaved Biphasic Pulse Sequencer

This block drives a shared current DAC and an electrode switch bridge. It produces one biphasic pulse on each active electrode in turn, once per stimulation frame. A frame begins on a rising edge of a slow frame clock, which is sampled by the fast waveform clock that runs the whole block. The DAC supply is enabled first. Stimulation is enabled one waveform-clock cycle later. The block then walks through the active channels in a fixed order. For each channel it runs a cathodic phase, an optional gap, an anodic phase and a shorting interval. When the last channel has finished, the supply enable and the stimulation enable drop together.

The pulse shape comes from a 16-entry table of step weights. Entries 0 to 7 shape the cathodic half and entries 8 to 15 shape the anodic half. In every phase cycle the DAC code is the current step's weight multiplied by the active channel's magnitude. The product is shifted right by the weight width and saturated to the DAC code width. Channel mode, gap enable, gap length and short length are captured at the start of each frame. A frame-clock edge that arrives while a frame is running does not restart it. It only raises a one-cycle overrun flag.

States: IDLE (waiting for a frame edge), PWRUP (supply on, stimulation off), CATH (cathodic steps), GAP (both bridge legs open), ANOD (anodic steps), SHORT (electrode discharge). Transitions: IDLE to PWRUP on a frame edge; PWRUP to CATH after one cycle; CATH to GAP after step 7 when the gap is enabled, otherwise CATH to ANOD; GAP to ANOD after gap_len+1 cycles; ANOD to SHORT after step 15; SHORT to CATH for the next channel after short_len+1 cycles, or SHORT to IDLE after the last channel.

Top module: `stim_seq`

## Requirements
- R1: While reset is held, and right after reset, every output is low: both enables, all three bridge controls, the overrun flag, elec_sel and dac_code (0).
- R2: The first clock edge that sees frame_clk high after it was low starts a frame. On that edge dac_pwr_en rises with stim_en still low, and on the next edge stim_en rises.
- R3: Channel order is ascending and depends on chan_mode as captured at frame start. Mode 0 uses channels 0 to 7. Mode 1 uses 0, 1, 2, 4, 5, 6. Modes 2 and 3 use 0, 2, 4, 6. A change of chan_mode during a frame has no effect on that frame.
- R4: Each channel's cathodic phase is 8 cycles with cath_on high, using weights 0 to 7 in order. Its anodic phase is 8 cycles with anod_on high, using weights 8 to 15 in order.
- R5: During a phase cycle, dac_code = min(63, (weight × magnitude) >> 6). The channel's magnitude is bits [6c+5:6c] of mag_flat.
- R6: When gap_en was set at frame start, gap_len+1 cycles separate the two phases. During those cycles no bridge control is high and dac_code is 0. When it was clear, the anodic phase starts on the cycle right after the last cathodic cycle.
- R7: After the anodic phase, short_on is high for short_len+1 cycles with dac_code 0.
- R8: After the last channel's short interval, dac_pwr_en and stim_en fall on the same edge. elec_sel and dac_code return to 0.
- R9: At most one of cath_on, anod_on and short_on is high in any cycle, and none is high unless stim_en is high. elec_sel holds the active channel from the first cathodic cycle to the last short cycle.
- R10: A frame-clock rising edge seen while a frame runs leaves the frame unchanged and sets frame_overrun for exactly the following cycle.
- R11: After reset every weight is 63. A clock edge with wt_we high writes wt_data into entry wt_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Waveform clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_clk | input | 1 | Frame clock, rising edge starts a frame |
| chan_mode | input | 2 | 0: eight channels, 1: six, 2/3: four |
| gap_en | input | 1 | Insert an inter-phase gap |
| gap_len | input | 4 | Gap length minus one, in clock cycles |
| short_len | input | 4 | Short length minus one, in clock cycles |
| wt_we | input | 1 | Weight write strobe |
| wt_addr | input | 4 | Weight entry to write |
| wt_data | input | 6 | Weight value to write |
| mag_flat | input | 48 | Eight 6-bit channel magnitudes, channel 0 in the low bits |
| dac_pwr_en | output | 1 | DAC supply enable |
| stim_en | output | 1 | Stimulation enable |
| elec_sel | output | 3 | Active electrode |
| cath_on | output | 1 | Bridge set for cathodic current |
| anod_on | output | 1 | Bridge set for anodic current |
| short_on | output | 1 | Electrode shorting switch |
| dac_code | output | 6 | Current DAC code |
| frame_overrun | output | 1 | One-cycle flag for an ignored frame edge |

## Verification
The hardest case to reach from the ports is a frame edge arriving in the middle of a running frame, together with a mode change after the frame has started. Either one could silently reshape the rest of the frame. The bench raises frame_clk again partway through a four-channel frame and changes chan_mode one cycle after the frame starts. It then compares every following cycle against a timeline built from the captured settings, so any restart, truncation or reordering shows up as a mismatch.

// File: rtl/stim_pkg.sv
package stim_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PWRUP,
        ST_CATH,
        ST_GAP,
        ST_ANOD,
        ST_SHORT
    } stim_state_t;

    localparam logic [1:0] MODE_FULL = 2'd0;
    localparam logic [1:0] MODE_MID  = 2'd1;
endpackage

// File: rtl/stim_wt_table.sv
module stim_wt_table #(
    parameter int N_STEPS = 16,
    parameter int WT_W    = 6,
    localparam int STEP_W = $clog2(N_STEPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [STEP_W-1:0] wr_addr,
    input  logic [WT_W-1:0]   wr_data,
    input  logic [STEP_W-1:0] rd_addr,
    output logic [WT_W-1:0]   rd_data
);
    logic [WT_W-1:0] entry [N_STEPS];

    for (genvar i = 0; i < N_STEPS; i++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                entry[i] <= '1;
            else if (we && (wr_addr == STEP_W'(i)))
                entry[i] <= wr_data;
        end
    end

    assign rd_data = entry[rd_addr];
endmodule

// File: rtl/stim_chan_order.sv
module stim_chan_order #(
    parameter int N_CH = 8,
    localparam int SEL_W = $clog2(N_CH),
    localparam int HALF_CH = N_CH / 2
) (
    input  logic [1:0]       mode,
    input  logic [SEL_W-1:0] slot,
    output logic [SEL_W-1:0] chan,
    output logic             last
);
    import stim_pkg::*;

    always_comb begin
        if (mode == MODE_FULL) begin
            chan = slot;
            last = (slot == SEL_W'(N_CH - 1));
        end else if (mode == MODE_MID) begin
            chan = (slot < SEL_W'(HALF_CH - 1)) ? slot : SEL_W'(slot + 1'b1);
            last = (slot == SEL_W'(N_CH - 3));
        end else begin
            chan = SEL_W'(slot << 1);
            last = (slot == SEL_W'(HALF_CH - 1));
        end
    end
endmodule

// File: rtl/stim_dac_scale.sv
module stim_dac_scale #(
    parameter int WT_W  = 6,
    parameter int MAG_W = 6,
    parameter int DAC_W = 6,
    localparam int PROD_W = WT_W + MAG_W
) (
    input  logic [WT_W-1:0]  weight,
    input  logic [MAG_W-1:0] mag,
    output logic [DAC_W-1:0] code
);
    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] shifted;

    always_comb begin
        prod    = PROD_W'(weight) * PROD_W'(mag);
        shifted = prod >> WT_W;
        if (shifted > PROD_W'({DAC_W{1'b1}}))
            code = '1;
        else
            code = shifted[DAC_W-1:0];
    end
endmodule

// File: rtl/stim_seq.sv
module stim_seq #(
    parameter int N_CH    = 8,
    parameter int N_STEPS = 16,
    parameter int WT_W    = 6,
    parameter int MAG_W   = 6,
    parameter int DAC_W   = 6,
    parameter int CNT_W   = 4,
    localparam int SEL_W  = $clog2(N_CH),
    localparam int STEP_W = $clog2(N_STEPS),
    localparam int HALF   = N_STEPS / 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   frame_clk,
    input  logic [1:0]             chan_mode,
    input  logic                   gap_en,
    input  logic [CNT_W-1:0]       gap_len,
    input  logic [CNT_W-1:0]       short_len,
    input  logic                   wt_we,
    input  logic [STEP_W-1:0]      wt_addr,
    input  logic [WT_W-1:0]        wt_data,
    input  logic [N_CH*MAG_W-1:0]  mag_flat,
    output logic                   dac_pwr_en,
    output logic                   stim_en,
    output logic [SEL_W-1:0]       elec_sel,
    output logic                   cath_on,
    output logic                   anod_on,
    output logic                   short_on,
    output logic [DAC_W-1:0]       dac_code,
    output logic                   frame_overrun
);
    import stim_pkg::*;

    stim_state_t       st, st_n;
    logic [STEP_W-1:0] step, step_n;
    logic [CNT_W-1:0]  ivl, ivl_n;
    logic [SEL_W-1:0]  slot, slot_n;
    logic [1:0]        mode_q;
    logic              gap_q;
    logic [CNT_W-1:0]  gap_len_q, short_len_q;
    logic              frm_q, ovr_q, tick;
    logic [SEL_W-1:0]  chan;
    logic              last_slot;
    logic [WT_W-1:0]   weight;
    logic [MAG_W-1:0]  mag;
    logic [DAC_W-1:0]  scaled;

    assign tick = frame_clk & ~frm_q;

    stim_wt_table #(.N_STEPS(N_STEPS), .WT_W(WT_W)) wt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (wt_we),
        .wr_addr (wt_addr),
        .wr_data (wt_data),
        .rd_addr (step),
        .rd_data (weight)
    );

    stim_chan_order #(.N_CH(N_CH)) ord_i (
        .mode (mode_q),
        .slot (slot),
        .chan (chan),
        .last (last_slot)
    );

    assign mag = mag_flat[chan*MAG_W +: MAG_W];

    stim_dac_scale #(.WT_W(WT_W), .MAG_W(MAG_W), .DAC_W(DAC_W)) scl_i (
        .weight (weight),
        .mag    (mag),
        .code   (scaled)
    );

    // State register, counters and frame configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st          <= ST_IDLE;
            step        <= '0;
            ivl         <= '0;
            slot        <= '0;
            frm_q       <= 1'b0;
            ovr_q       <= 1'b0;
            mode_q      <= '0;
            gap_q       <= 1'b0;
            gap_len_q   <= '0;
            short_len_q <= '0;
        end else begin
            st    <= st_n;
            step  <= step_n;
            ivl   <= ivl_n;
            slot  <= slot_n;
            frm_q <= frame_clk;
            ovr_q <= tick && (st != ST_IDLE);
            if (st == ST_IDLE && tick) begin
                mode_q      <= chan_mode;
                gap_q       <= gap_en;
                gap_len_q   <= gap_len;
                short_len_q <= short_len;
            end
        end
    end

    // Next-state logic
    always_comb begin
        st_n   = st;
        step_n = step;
        ivl_n  = ivl;
        slot_n = slot;
        unique case (st)
            ST_IDLE: begin
                if (tick) begin
                    st_n   = ST_PWRUP;
                    step_n = '0;
                    slot_n = '0;
                end
            end
            ST_PWRUP: begin
                st_n   = ST_CATH;
                step_n = '0;
            end
            ST_CATH: begin
                step_n = STEP_W'(step + 1'b1);
                if (step == STEP_W'(HALF - 1)) begin
                    ivl_n = '0;
                    st_n  = gap_q ? ST_GAP : ST_ANOD;
                end
            end
            ST_GAP: begin
                ivl_n = CNT_W'(ivl + 1'b1);
                if (ivl == gap_len_q)
                    st_n = ST_ANOD;
            end
            ST_ANOD: begin
                step_n = STEP_W'(step + 1'b1);
                if (step == STEP_W'(N_STEPS - 1)) begin
                    ivl_n = '0;
                    st_n  = ST_SHORT;
                end
            end
            ST_SHORT: begin
                ivl_n = CNT_W'(ivl + 1'b1);
                if (ivl == short_len_q) begin
                    step_n = '0;
                    if (last_slot) begin
                        st_n   = ST_IDLE;
                        slot_n = '0;
                    end else begin
                        st_n   = ST_CATH;
                        slot_n = SEL_W'(slot + 1'b1);
                    end
                end
            end
        endcase
    end

    // Output logic
    always_comb begin
        dac_pwr_en    = 1'b0;
        stim_en       = 1'b0;
        elec_sel      = '0;
        cath_on       = 1'b0;
        anod_on       = 1'b0;
        short_on      = 1'b0;
        dac_code      = '0;
        frame_overrun = ovr_q;
        unique case (st)
            ST_IDLE: begin
            end
            ST_PWRUP: begin
                dac_pwr_en = 1'b1;
            end
            ST_CATH: begin
                dac_pwr_en = 1'b1;
                stim_en    = 1'b1;
                elec_sel   = chan;
                cath_on    = 1'b1;
                dac_code   = scaled;
            end
            ST_GAP: begin
                dac_pwr_en = 1'b1;
                stim_en    = 1'b1;
                elec_sel   = chan;
            end
            ST_ANOD: begin
                dac_pwr_en = 1'b1;
                stim_en    = 1'b1;
                elec_sel   = chan;
                anod_on    = 1'b1;
                dac_code   = scaled;
            end
            ST_SHORT: begin
                dac_pwr_en = 1'b1;
                stim_en    = 1'b1;
                elec_sel   = chan;
                short_on   = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/stim_seq_chk.sv
module stim_seq_chk #(
    parameter int DAC_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dac_pwr_en,
    input logic             stim_en,
    input logic             cath_on,
    input logic             anod_on,
    input logic             short_on,
    input logic [DAC_W-1:0] dac_code,
    input logic             frame_overrun
);
    // R9
    legs_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cath_on, anod_on, short_on}));

    // R9
    legs_need_stim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cath_on || anod_on || short_on) |-> (stim_en && dac_pwr_en));

    // R2
    pwr_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac_pwr_en) |-> !stim_en);

    // R2
    stim_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac_pwr_en) |=> $rose(stim_en));

    // R8
    enables_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dac_pwr_en) |-> $fell(stim_en));

    // R6
    dac_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cath_on && !anod_on) |-> (dac_code == '0));

    // R10
    overrun_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_overrun |-> $past(dac_pwr_en));
endmodule

bind stim_seq stim_seq_chk #(.DAC_W(DAC_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .dac_pwr_en    (dac_pwr_en),
    .stim_en       (stim_en),
    .cath_on       (cath_on),
    .anod_on       (anod_on),
    .short_on      (short_on),
    .dac_code      (dac_code),
    .frame_overrun (frame_overrun)
);

// File: tb/stim_seq_tb_top.sv
`timescale 1ns/1ps
module stim_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_clk = 1'b0;
    logic [1:0]  chan_mode = 2'd0;
    logic        gap_en = 1'b0;
    logic [3:0]  gap_len = 4'd0;
    logic [3:0]  short_len = 4'd0;
    logic        wt_we = 1'b0;
    logic [3:0]  wt_addr = 4'd0;
    logic [5:0]  wt_data = 6'd0;
    logic [47:0] mag_flat = 48'd0;
    logic        dac_pwr_en, stim_en, cath_on, anod_on, short_on, frame_overrun;
    logic [2:0]  elec_sel;
    logic [5:0]  dac_code;

    int checks = 0;
    int failures = 0;
    int it;
    int ovr_at_g;
    logic [1:0] md_after_g;
    int wt [16];
    int mg [8];

    always #10 clk = ~clk;

    stim_seq dut_i (
        .clk(clk), .rst_n(rst_n), .frame_clk(frame_clk), .chan_mode(chan_mode),
        .gap_en(gap_en), .gap_len(gap_len), .short_len(short_len),
        .wt_we(wt_we), .wt_addr(wt_addr), .wt_data(wt_data), .mag_flat(mag_flat),
        .dac_pwr_en(dac_pwr_en), .stim_en(stim_en), .elec_sel(elec_sel),
        .cath_on(cath_on), .anod_on(anod_on), .short_on(short_on),
        .dac_code(dac_code), .frame_overrun(frame_overrun)
    );

    function automatic logic [14:0] mk(input logic p, input logic s, input logic c,
                                       input logic a, input logic sh, input int sel, input int dac);
        return {p, s, c, a, sh, 1'b0, 3'(sel), 6'(dac)};
    endfunction

    function automatic logic [14:0] observed();
        return {dac_pwr_en, stim_en, cath_on, anod_on, short_on, frame_overrun, elec_sel, dac_code};
    endfunction

    function automatic int expect_code(input int w, input int m);
        int p = (w * m) >> 6;
        return (p > 63) ? 63 : p;
    endfunction

    function automatic int chan_of(input logic [1:0] md, input int s);
        if (md == 2'd0) return s;
        if (md == 2'd1) return (s < 3) ? s : s + 1;
        return 2 * s;
    endfunction

    task automatic check(input string req, input logic [14:0] got, input logic [14:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s cycle %0d got=%h expected=%h", req, it, got, exp);
        end
    endtask

    task automatic set_mags();
        for (int c = 0; c < 8; c++) mag_flat[c*6 +: 6] = 6'(mg[c]);
    endtask

    task automatic write_wt(input int a, input int d);
        wt_we = 1'b1; wt_addr = 4'(a); wt_data = 6'(d);
        @(posedge clk); @(negedge clk);
        wt_we = 1'b0;
        wt[a] = d;
    endtask

    task automatic cyc(input string req, input logic [14:0] exp);
        logic [14:0] e = exp;
        if (it == 1) begin
            frame_clk = 1'b0;
            chan_mode = md_after_g;
        end
        if (it == ovr_at_g) frame_clk = 1'b1;
        if (it == ovr_at_g + 1) frame_clk = 1'b0;
        @(posedge clk); @(negedge clk);
        if (it == ovr_at_g) e[9] = 1'b1;
        check(req, observed(), e);
        it++;
    endtask

    // R2 R3 R4 R5 R6 R7 R8 R9 cycle-by-cycle frame check
    task automatic run_frame(input string tag, input logic [1:0] md, input logic ge,
                             input int gl, input int sl, input int ovr_at, input logic [1:0] md_after);
        int nslots = (md == 2'd0) ? 8 : (md == 2'd1) ? 6 : 4;
        chan_mode = md; gap_en = ge; gap_len = 4'(gl); short_len = 4'(sl);
        ovr_at_g = ovr_at; md_after_g = md_after; it = 0;
        frame_clk = 1'b1;
        cyc({tag, " R2 powerup"}, mk(1, 0, 0, 0, 0, 0, 0));
        for (int s = 0; s < nslots; s++) begin
            int ch = chan_of(md, s);
            for (int k = 0; k < 8; k++)
                cyc({tag, " R4 R5 cathodic"}, mk(1, 1, 1, 0, 0, ch, expect_code(wt[k], mg[ch])));
            if (ge)
                for (int g = 0; g <= gl; g++)
                    cyc({tag, " R6 gap"}, mk(1, 1, 0, 0, 0, ch, 0));
            for (int k = 8; k < 16; k++)
                cyc({tag, " R4 R5 anodic"}, mk(1, 1, 0, 1, 0, ch, expect_code(wt[k], mg[ch])));
            for (int j = 0; j <= sl; j++)
                cyc({tag, " R7 short"}, mk(1, 1, 0, 0, 1, ch, 0));
        end
        cyc({tag, " R8 end"}, mk(0, 0, 0, 0, 0, 0, 0));
        cyc({tag, " R8 idle"}, mk(0, 0, 0, 0, 0, 0, 0));
    endtask

    task automatic t_reset();
        it = 0;
        @(negedge clk);
        check("R1 in reset", observed(), 15'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", observed(), 15'd0);
        for (int k = 0; k < 16; k++) wt[k] = 63;   // R11 reset weights
    endtask

    task automatic t_rect_eight();
        for (int c = 0; c < 8; c++) mg[c] = 8 * c + 7;
        set_mags();
        run_frame("rect8 R3 R11", 2'd0, 1'b0, 0, 0, -10, 2'd0);
    endtask

    task automatic t_shaped_six();
        for (int k = 0; k < 16; k++) write_wt(k, 4 * k + 3);   // R11
        for (int c = 0; c < 8; c++) mg[c] = 63 - 5 * c;
        set_mags();
        run_frame("shaped6 R3 R11", 2'd1, 1'b1, 3, 2, -10, 2'd1);
    endtask

    task automatic t_four_latch();
        write_wt(0, 0); write_wt(15, 63);
        mg[0] = 0; mg[6] = 63;
        set_mags();
        run_frame("four R3 latch", 2'd2, 1'b1, 0, 5, -10, 2'd0);
    endtask

    task automatic t_overrun();
        run_frame("ovr R10", 2'd3, 1'b0, 0, 1, 20, 2'd3);
    endtask

    initial begin
        #(200000 * 20);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_rect_eight();
        t_shaped_six();
        t_four_latch();
        t_overrun();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule